// File: doc/BRIEF.md
# Flash Status Polling Engine

This block runs on the host side once a program or erase command has already been sent to a flash device. It reads the status word at the target address again and again and decides whether the operation passed, failed or is still in progress. It can decide in one of two ways. In data-compare mode it checks status bit 7 against bit 7 of the word that was written. In toggle mode it checks whether bit 6, and optionally bit 2, changes from one read to the next. In both modes, bit 5 set while the device still looks busy causes exactly one confirming read.

A single-cycle start pulse loads the target address, the expected word, the method and a limit on busy polls. The engine then makes single-cycle read requests and waits for each response. When it reaches a verdict it pulses done and holds a 2-bit result code until the next accepted start. Issuing the flash commands and any retry policy are handled elsewhere.

Top module: `fsp_poller`

## Requirements
- R1: A start pulse is accepted only while busy is low. It latches the target address, expected word, method and poll limit. Every read request is a one-cycle pulse on rd_req with rd_addr equal to the latched target.
- R2: Method 0 (data compare): a status read whose bit 7 equals bit 7 of the expected word ends with pass.
- R3: Method 0: a read whose bit 7 differs and whose bit 5 is 0 is a busy poll, and another read follows.
- R4: Method 0: a read whose bit 7 differs and whose bit 5 is 1 triggers exactly one more read. That read ends with pass if its bit 7 matches and with fail otherwise.
- R5: Method 1 (toggle on bit 6): the first read only serves as a reference. A later read whose bit 6 equals that of the previous read ends with pass. A changed bit 6 with bit 5 at 0 is a busy poll.
- R6: Toggle methods: a toggled read with bit 5 at 1 triggers exactly one more read. That read ends with fail if it still toggles against the previous read and with pass otherwise.
- R7: Methods 2 and 3 also count a change of bit 2 as toggling. Method 1 ignores bit 2.
- R8: When the number of busy polls reaches max_polls (0 acts as 1), the operation ends with timeout and no further read is made.
- R9: Result codes are 00 none, 01 pass, 10 fail and 11 timeout. done pulses for one cycle in the same cycle the result code appears. The code is held until the next accepted start, which clears it to 00.
- R10: After reset, busy, done and rd_req are 0 and result is 00.
- R11: A start pulse while busy is ignored: the read sequence and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (one-cycle pulse) |
| target_addr | input | AW | Address to poll |
| expect_word | input | DW | Word that was programmed |
| method | input | 2 | 0 data compare, 1 toggle bit 6, 2/3 toggle bits 6 and 2 |
| max_polls | input | CW | Limit on busy polls |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DW | Status word read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code |

## Verification
The checker watches properties on every cycle: read requests last one cycle and appear only while busy, done lasts one cycle and always comes with a non-zero code, an accepted start raises busy, and the code stays stable while idle with no start. The outcome of each decision path can only be shown by the bench's scripted status sequences. These paths are the data-compare match, the confirming read after bit 5, toggle detection with and without bit 2, and the busy-poll limit. The bench checks each path's result code and its exact number of reads.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_PASS    = 2'b01,
    RES_FAIL    = 2'b10,
    RES_TIMEOUT = 2'b11
  } fsp_result_e;

  typedef enum logic [2:0] {
    V_PASS,
    V_FAIL,
    V_CONFIRM,
    V_BUSY,
    V_REFONLY
  } fsp_verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } fsp_state_e;

  localparam int unsigned BIT_DPOLL  = 7;
  localparam int unsigned BIT_TOGA   = 6;
  localparam int unsigned BIT_ERR    = 5;
  localparam int unsigned BIT_TOGB   = 2;
endpackage

// File: rtl/fsp_judge.sv
module fsp_judge
  import fsp_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0]  data,
  input  logic           exp_bit,
  input  logic [1:0]     method,
  input  logic           ref_ok,
  input  logic           ref_a,
  input  logic           ref_b,
  input  logic           confirming,
  output fsp_verdict_e   verdict
);
  logic match;
  logic toggled;
  logic use_b;

  assign match   = (data[BIT_DPOLL] == exp_bit);
  assign use_b   = method[1];
  assign toggled = (data[BIT_TOGA] != ref_a) | (use_b & (data[BIT_TOGB] != ref_b));

  always_comb begin
    verdict = V_BUSY;
    if (method == 2'd0) begin
      if (match)                verdict = V_PASS;
      else if (confirming)      verdict = V_FAIL;
      else if (data[BIT_ERR])   verdict = V_CONFIRM;
      else                      verdict = V_BUSY;
    end else begin
      if (!ref_ok)              verdict = V_REFONLY;
      else if (!toggled)        verdict = V_PASS;
      else if (confirming)      verdict = V_FAIL;
      else if (data[BIT_ERR])   verdict = V_CONFIRM;
      else                      verdict = V_BUSY;
    end
  end
endmodule

// File: rtl/fsp_poll_counter.sv
module fsp_poll_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          at_last
);
  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [XW-1:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + XW'(1);
  assign at_last  = (cnt_plus >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_plus[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || inc)  cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fsp_ref_store.sv
module fsp_ref_store (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic bit_a,
  input  logic bit_b,
  output logic ref_ok,
  output logic ref_a,
  output logic ref_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ok <= 1'b0;
      ref_a  <= 1'b0;
      ref_b  <= 1'b0;
    end else if (clr) begin
      ref_ok <= 1'b0;
    end else if (load) begin
      ref_ok <= 1'b1;
      ref_a  <= bit_a;
      ref_b  <= bit_b;
    end
  end
endmodule

// File: rtl/fsp_poller.sv
module fsp_poller
  import fsp_pkg::*;
#(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] target_addr,
  input  logic [DW-1:0] expect_word,
  input  logic [1:0]    method,
  input  logic [CW-1:0] max_polls,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);
  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  fsp_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          exp_q;
  logic [1:0]    method_q;
  logic [CW-1:0] limit_q;
  logic          confirm_q, confirm_d;
  fsp_result_e   result_q, result_d;
  logic          done_q, done_d;

  logic          accept;
  logic          resp;
  logic          cnt_clr, cnt_inc, cnt_last;
  logic          ref_ok, ref_a, ref_b, ref_load;
  fsp_verdict_e  verdict;

  assign accept = start && (state_q == ST_IDLE);
  assign resp   = rd_valid && (state_q == ST_WAIT);

  fsp_judge #(.DW(DW)) u_judge (
    .data       (rd_data),
    .exp_bit    (exp_q),
    .method     (method_q),
    .ref_ok     (ref_ok),
    .ref_a      (ref_a),
    .ref_b      (ref_b),
    .confirming (confirm_q),
    .verdict    (verdict)
  );

  fsp_poll_counter #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rs_n),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .limit   (limit_q),
    .at_last (cnt_last)
  );

  assign ref_load = resp && (method_q != 2'd0);

  fsp_ref_store u_ref (
    .clk    (clk),
    .rst_n  (rs_n),
    .clr    (accept),
    .load   (ref_load),
    .bit_a  (rd_data[BIT_TOGA]),
    .bit_b  (rd_data[BIT_TOGB]),
    .ref_ok (ref_ok),
    .ref_a  (ref_a),
    .ref_b  (ref_b)
  );

  always_comb begin
    state_d   = state_q;
    confirm_d = confirm_q;
    result_d  = result_q;
    done_d    = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_ISSUE;
          confirm_d = 1'b0;
          result_d  = RES_NONE;
          cnt_clr   = 1'b1;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid) begin
          unique case (verdict)
            V_PASS: begin
              state_d = ST_IDLE; result_d = RES_PASS; done_d = 1'b1;
            end
            V_FAIL: begin
              state_d = ST_IDLE; result_d = RES_FAIL; done_d = 1'b1;
            end
            V_CONFIRM: begin
              state_d = ST_ISSUE; confirm_d = 1'b1;
            end
            V_BUSY: begin
              if (cnt_last) begin
                state_d = ST_IDLE; result_d = RES_TIMEOUT; done_d = 1'b1;
              end else begin
                state_d = ST_ISSUE; cnt_inc = 1'b1;
              end
            end
            default: state_d = ST_ISSUE;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q   <= ST_IDLE;
      confirm_q <= 1'b0;
      result_q  <= RES_NONE;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      confirm_q <= confirm_d;
      result_q  <= result_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      addr_q   <= '0;
      exp_q    <= 1'b0;
      method_q <= 2'd0;
      limit_q  <= '0;
    end else if (accept) begin
      addr_q   <= target_addr;
      exp_q    <= expect_word[BIT_DPOLL];
      method_q <= method;
      limit_q  <= max_polls;
    end
  end

  assign rd_req  = (state_q == ST_ISSUE);
  assign rd_addr = addr_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign result  = result_q;
endmodule

// File: rtl/fsp_poller_chk.sv
module fsp_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rd_req,
  input logic       busy,
  input logic       done,
  input logic [1:0] result
);
  // R1
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R1
  rd_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'b00) && !busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind fsp_poller fsp_poller_chk u_chk (
  .clk    (clk),
  .rst_n  (rs_n),
  .start  (start),
  .rd_req (rd_req),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/fsp_poller_bench.sv
module fsp_poller_bench;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic [DW-1:0] expect_word = '0;
  logic [1:0]    method = 2'd0;
  logic [CW-1:0] max_polls = 16'd8;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done;
  logic [1:0]    result;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  int idx = 0;
  int cycles = 0;
  logic [DW-1:0] script [0:15];

  always #4 clk = ~clk;

  fsp_poller #(.AW(AW), .DW(DW), .CW(CW)) u_fsp_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .target_addr(target_addr),
    .expect_word(expect_word), .method(method), .max_polls(max_polls),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .result(result)
  );

  // flash model: answers each request with the next scripted word
  int pend = 0;
  int dly = 0;
  always @(negedge clk) begin
    rd_valid = 1'b0;
    if (rd_req) begin
      nreads++;
      checks++;
      if (rd_addr !== target_addr) begin
        errors++;
        $display("FAIL R1 rd_addr actual %h expected %h", rd_addr, target_addr);
      end
      pend = 1;
      dly = LAT;
    end else if (pend == 1) begin
      dly--;
      if (dly == 0) begin
        rd_valid = 1'b1;
        rd_data  = script[idx];
        idx++;
        pend = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [DW-1:0] ew,
                     input logic [CW-1:0] lim, input logic [AW-1:0] a,
                     input bit poke_start);
    int t;
    idx = 0;
    nreads = 0;
    @(negedge clk);
    method = m; expect_word = ew; max_polls = lim; target_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    method = ~m; max_polls = 16'd1;
    t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
      if (poke_start && t == 3) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 rd_req", rd_req, 0);
    check("R10 result", result, 0);
  endtask

  task automatic t_data_match();
    script[0] = 16'h0080;
    run(2'd0, 16'h00FF, 16'd8, 21'h1ABCD, 1'b0);
    check("R2 result", result, 1);
    check("R2 reads", nreads, 1);
  endtask

  task automatic t_data_busy();
    script[0] = 16'h0080; script[1] = 16'h0080; script[2] = 16'h0000;
    run(2'd0, 16'h0012, 16'd8, 21'h00100, 1'b0);
    check("R3 result", result, 1);
    check("R3 reads", nreads, 3);
  endtask

  task automatic t_err_pass();
    script[0] = 16'h0020; script[1] = 16'h0080;
    run(2'd0, 16'h0080, 16'd8, 21'h00200, 1'b0);
    check("R4 pass result", result, 1);
    check("R4 pass reads", nreads, 2);
  endtask

  task automatic t_err_fail();
    script[0] = 16'h0020; script[1] = 16'h0000; script[2] = 16'h0080;
    run(2'd0, 16'h0080, 16'd8, 21'h00300, 1'b0);
    check("R4 fail result", result, 2);
    check("R4 fail reads", nreads, 2);
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 8; i++) script[i] = 16'h0000;
    run(2'd0, 16'h0080, 16'd3, 21'h00400, 1'b1);
    check("R8 result", result, 3);
    check("R8 reads", nreads, 3);
    check("R11 reads unchanged", nreads, 3);
    repeat (6) @(negedge clk);
    check("R8 no extra reads", nreads, 3);
    check("R9 result held", result, 3);
    check("R9 busy low", busy, 0);
  endtask

  task automatic t_zero_limit();
    for (int i = 0; i < 4; i++) script[i] = 16'h0000;
    run(2'd0, 16'h0080, 16'd0, 21'h00410, 1'b0);
    check("R8 zero limit result", result, 3);
    check("R8 zero limit reads", nreads, 1);
  endtask

  task automatic t_tog_pass();
    script[0] = 16'h0040; script[1] = 16'h0000; script[2] = 16'h0000;
    run(2'd1, 16'h0000, 16'd8, 21'h00500, 1'b0);
    check("R5 result", result, 1);
    check("R5 reads", nreads, 3);
  endtask

  task automatic t_tog_fail();
    script[0] = 16'h0040; script[1] = 16'h0020; script[2] = 16'h0040;
    run(2'd1, 16'h0000, 16'd8, 21'h00600, 1'b0);
    check("R6 fail result", result, 2);
    check("R6 fail reads", nreads, 3);
  endtask

  task automatic t_tog_err_pass();
    script[0] = 16'h0040; script[1] = 16'h0020; script[2] = 16'h0000;
    run(2'd1, 16'h0000, 16'd8, 21'h00610, 1'b0);
    check("R6 pass result", result, 1);
    check("R6 pass reads", nreads, 3);
  endtask

  task automatic t_bit2();
    script[0] = 16'h0004; script[1] = 16'h0000; script[2] = 16'h0000;
    run(2'd2, 16'h0000, 16'd8, 21'h00700, 1'b0);
    check("R7 method2 result", result, 1);
    check("R7 method2 reads", nreads, 3);
    run(2'd1, 16'h0000, 16'd8, 21'h00710, 1'b0);
    check("R7 method1 result", result, 1);
    check("R7 method1 reads", nreads, 2);
  endtask

  task automatic t_clear_on_start();
    script[0] = 16'h0000;
    @(negedge clk);
    method = 2'd0; expect_word = 16'h0000; target_addr = 21'h00800;
    max_polls = 16'd4; idx = 0; nreads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 cleared on start", result, 0);
    check("R1 busy after start", busy, 1);
    while (!done) @(negedge clk);
    check("R9 done with pass", result, 1);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_data_match();
    t_data_busy();
    t_err_pass();
    t_err_fail();
    t_timeout();
    t_zero_limit();
    t_tog_pass();
    t_tog_fail();
    t_tog_err_pass();
    t_bit2();
    t_clear_on_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule